// File: doc/BRIEF.md
# Rotating-Priority Interrupt Arbiter

The block picks one winner among N interrupt request lines when the priority order is not fixed but set at run time. A rotation amount held in a register moves every request line to a new position in a circular order: line i lands on position (i + rot) mod N, and the line in the highest position wins. Internally the request vector is barrel-rotated, a fixed highest-position encoder runs on the rotated vector, and the winning position is mapped back to the original line number by subtracting the rotation amount modulo N.

The rotation amount is written from a load port. It can also move by itself: in fair mode, each grant that the consumer accepts rewrites the rotation so that the line just served becomes the lowest-priority line in the next round. The result is round-robin service among active requesters. The grant path is purely combinational, and the rotation register changes only on a clock edge.

Top module: `rpa_arbiter`

## Requirements
- R1: While reset is active, and after it, until the first write, the rotation amount is 0. With every line requesting, the granted index is then N-1.
- R2: `grant_vld` is high exactly when at least one request line is high. When no line is high, `grant_idx` is 0.
- R3: With rotation amount p, the granted line is the requesting line i with the greatest value of (i + p) mod N.
- R4: Whenever `grant_vld` is high, the request line named by `grant_idx` is high.
- R5: When `rot_ld` is high at a rising clock edge (reset released), the rotation amount takes the value of `rot_ld_val`, whatever the other inputs are.
- R6: When `rot_ld` and a fair-mode advance happen in the same cycle, the load wins.
- R7: When `fair_en`, `grant_ack` and `grant_vld` are all high and `rot_ld` is low, the rotation amount becomes (N - grant_idx) mod N at the clock edge. The line just served therefore moves to position 0, the lowest priority.
- R8: Without a load, the rotation amount does not change if `fair_en` is low, `grant_ack` is low, or no request is present.
- R9: `grant_vld` and `grant_idx` follow a change on `req` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| req | input | N | Interrupt request lines, one bit per requester |
| fair_en | input | 1 | Enables the rotation update after each accepted grant |
| rot_ld | input | 1 | Writes `rot_ld_val` into the rotation register |
| rot_ld_val | input | log2(N) | Rotation amount to write |
| grant_ack | input | 1 | The consumer accepts the current grant |
| grant_vld | output | 1 | At least one request is present |
| grant_idx | output | log2(N) | Line number of the winning request |

## Verification
On every cycle the assertions check that the valid flag matches the presence of a request and the index is zero when idle, that a valid grant always names a requesting line, and that the rotation register changes only through a load (which takes that value) or an accepted fair grant (which takes the negated winner). No assertion computes the winner itself. The exact circular order, meaning that the chosen line is the one that comes highest after rotation for every request pattern and every rotation amount, is shown only by the bench's full sweep. So are the round-robin order that fair mode produces over long sequences and the reset value seen from the grant.

// File: rtl/rpa_pkg.sv
`timescale 1ns/1ps
package rpa_pkg;
  // Source selected for the next rotation value.
  typedef enum logic [1:0] {
    ROT_HOLD = 2'd0,
    ROT_LOAD = 2'd1,
    ROT_FAIR = 2'd2
  } rot_src_e;
endpackage

// File: rtl/rpa_rotate.sv
`timescale 1ns/1ps
// Circular rotation: input bit i appears at output position (i + amt) mod N.
module rpa_rotate #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_in,
  input  logic [W-1:0] amt,
  output logic [N-1:0] vec_out
);
  for (genvar j = 0; j < N; j++) begin : g_pos
    localparam logic [W-1:0] PosW = W'(j);
    logic [W-1:0] src;
    // Output position j takes input bit (j - amt) mod N, truncated to W bits.
    assign src        = PosW - amt;
    assign vec_out[j] = vec_in[src];
  end
endmodule

// File: rtl/rpa_hi_enc.sv
`timescale 1ns/1ps
// Fixed encoder: the highest set position wins.
module rpa_hi_enc #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) pos = W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/rpa_rot_reg.sv
`timescale 1ns/1ps
// Rotation register: a load has priority over the fair advance.
module rpa_rot_reg
  import rpa_pkg::*;
#(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         adv_en,
  input  logic [W-1:0] adv_val,
  output logic [W-1:0] rot_q
);
  rot_src_e     src;
  logic         upd_en;
  logic [W-1:0] rot_d;

  always_comb begin
    if (ld_en)       src = ROT_LOAD;
    else if (adv_en) src = ROT_FAIR;
    else             src = ROT_HOLD;
  end

  always_comb begin
    unique case (src)
      ROT_LOAD: rot_d = ld_val;
      ROT_FAIR: rot_d = adv_val;
      default:  rot_d = rot_q;
    endcase
  end

  assign upd_en = (src != ROT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rot_q <= '0;
    else if (upd_en) rot_q <= rot_d;
  end
endmodule

// File: rtl/rpa_arbiter.sv
`timescale 1ns/1ps
// Rotating-priority interrupt arbiter (top).
module rpa_arbiter #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         fair_en,
  input  logic         rot_ld,
  input  logic [W-1:0] rot_ld_val,
  input  logic         grant_ack,
  output logic         grant_vld,
  output logic [W-1:0] grant_idx
);
  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic [W-1:0] rot_q;
  logic [N-1:0] req_rot;
  logic         enc_any;
  logic [W-1:0] enc_pos;
  logic [W-1:0] win_idx;
  logic         adv_en;
  logic [W-1:0] adv_val;

  rpa_rotate #(.N(N)) u_rot (
    .vec_in (req),
    .amt    (rot_q),
    .vec_out(req_rot)
  );

  rpa_hi_enc #(.N(N)) u_enc (
    .vec(req_rot),
    .any(enc_any),
    .pos(enc_pos)
  );

  // Map back to line numbering: (pos - rot) mod N by truncation.
  always_comb begin
    win_idx = enc_pos - rot_q;
    if (!enc_any) win_idx = '0;
  end

  assign grant_vld = enc_any;
  assign grant_idx = win_idx;

  // Fair advance: the winner moves to rotated position 0.
  assign adv_en  = fair_en & grant_ack & enc_any;
  assign adv_val = '0 - win_idx;

  rpa_rot_reg #(.N(N)) u_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld_en  (rot_ld),
    .ld_val (rot_ld_val),
    .adv_en (adv_en),
    .adv_val(adv_val),
    .rot_q  (rot_q)
  );
endmodule

// File: rtl/rpa_arbiter_chk.sv
`timescale 1ns/1ps
module rpa_arbiter_chk #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic         fair_en,
  input logic         rot_ld,
  input logic [W-1:0] rot_ld_val,
  input logic         grant_ack,
  input logic         grant_vld,
  input logic [W-1:0] grant_idx,
  input logic [W-1:0] rot_q
);
  logic [W-1:0] neg_idx;
  logic         adv;

  always_comb neg_idx = '0 - grant_idx;
  assign adv = fair_en & grant_ack & grant_vld;

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (!grant_vld && grant_idx == '0));

  assert_vld_any_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> grant_vld);

  assert_grant_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> req[grant_idx]);

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rot_ld |=> (rot_q == $past(rot_ld_val)));

  assert_fair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !rot_ld) |=> (rot_q == $past(neg_idx)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_ld && !adv) |=> $stable(rot_q));
endmodule

bind rpa_arbiter rpa_arbiter_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req       (req),
  .fair_en   (fair_en),
  .rot_ld    (rot_ld),
  .rot_ld_val(rot_ld_val),
  .grant_ack (grant_ack),
  .grant_vld (grant_vld),
  .grant_idx (grant_idx),
  .rot_q     (rot_q)
);

// File: tb/sim_rpa_arbiter.sv
`timescale 1ns/1ps
module sim_rpa_arbiter;
  localparam int N = 8;
  localparam int W = $clog2(N);
  localparam int CYC_LIMIT = 200000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req;
  logic         fair_en;
  logic         rot_ld;
  logic [W-1:0] rot_ld_val;
  logic         grant_ack;
  logic         grant_vld;
  logic [W-1:0] grant_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [W-1:0] pm;   // model of the rotation amount

  always #10 clk = ~clk;  // 50 MHz

  rpa_arbiter #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .fair_en(fair_en),
    .rot_ld(rot_ld), .rot_ld_val(rot_ld_val), .grant_ack(grant_ack),
    .grant_vld(grant_vld), .grant_idx(grant_idx)
  );

  // R3: winner is the requesting line with the greatest (i + p) mod N.
  function automatic void model(input logic [N-1:0] r, input logic [W-1:0] p,
                                output logic v, output logic [W-1:0] g);
    int best;
    best = -1;
    g = '0;
    v = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (r[i] && ((i + int'(p)) % N) > best) begin
        best = (i + int'(p)) % N;
        g = W'(i);
        v = 1'b1;
      end
    end
  endfunction

  // One cycle: drive after the falling edge, check, then update the model at the rising edge.
  task automatic cyc(input logic [N-1:0] r, input logic f, input logic ld,
                     input logic [W-1:0] lv, input logic a, input logic live,
                     input string tag);
    logic         ev;
    logic [W-1:0] eg;
    req = r; fair_en = f; rot_ld = ld; rot_ld_val = lv; grant_ack = a;
    #1;
    model(r, pm, ev, eg);
    n_cmp++;
    if (grant_vld !== ev || grant_idx !== eg) begin
      n_bad++;
      $display("FAIL %s: req=%b p=%0d got vld=%0b idx=%0d expected vld=%0b idx=%0d",
               tag, r, pm, grant_vld, grant_idx, ev, eg);
    end
    if (live) begin
      if (ld)               pm = lv;          // R5, R6
      else if (f && a && ev) pm = '0 - eg;    // R7
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic live);
    for (int k = 0; k < n; k++) cyc('0, 1'b0, 1'b0, '0, 1'b0, live, "R2 idle");
  endtask

  initial begin
    logic [15:0] lfsr;
    string tg;
    rst_n = 1'b0;
    req = '0; fair_en = 1'b0; rot_ld = 1'b0; rot_ld_val = '0; grant_ack = 1'b0;
    pm = '0;
    @(negedge clk);
    // R1: reset state, with loads ignored while reset is held.
    cyc('1, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0, "R1 reset all-request");
    cyc('0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 R2 reset idle");
    cyc('1, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 reset ignores load");
    rst_n = 1'b1;
    idle(3, 1'b0);
    cyc('1, 1'b0, 1'b0, '0, 1'b1, 1'b1, "R1 after release");

    // R3, R9, R8: full sweep over every rotation and every request pattern;
    // grant_ack toggles with fair mode off and must not move the rotation.
    for (int p = 0; p < N; p++) begin
      cyc('0, 1'b0, 1'b1, W'(p), 1'b0, 1'b1, "R5 load");
      for (int r = 0; r < (1 << N); r++) begin
        tg = (r == 0) ? "R2 R8 sweep" : "R3 R8 R9 sweep";
        cyc(N'(r), 1'b0, 1'b0, '0, r[0], 1'b1, tg);
      end
    end

    // R7: fair mode with all lines active gives round-robin from the top down.
    cyc('0, 1'b0, 1'b1, '0, 1'b0, 1'b1, "R5 load zero");
    for (int k = 0; k < 2 * N; k++) cyc('1, 1'b1, 1'b0, '0, 1'b1, 1'b1, "R7 round robin");
    // R8: fair on but no acknowledge, then no requests.
    for (int k = 0; k < 4; k++) cyc(8'h5A, 1'b1, 1'b0, '0, 1'b0, 1'b1, "R8 no ack");
    for (int k = 0; k < 4; k++) cyc('0, 1'b1, 1'b0, '0, 1'b1, 1'b1, "R2 R8 no request");
    // R6: load and accepted fair grant in the same cycle.
    cyc(8'hFF, 1'b1, 1'b1, 3'd3, 1'b1, 1'b1, "R6 load beats fair");
    cyc(8'hFF, 1'b0, 1'b0, '0, 1'b0, 1'b1, "R6 after load");

    // Mixed pseudo-random traffic with an asynchronous reset in the middle.
    lfsr = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      logic ld;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ld = (lfsr[12:10] == 3'd0);
      tg = ld ? (lfsr[8] ? "R6 R5 mixed" : "R5 mixed") : "R3 R7 mixed";
      if (k == 1000) begin
        rst_n = 1'b0;
        #1;
        pm = '0;
        cyc('1, 1'b1, 1'b1, 3'd6, 1'b1, 1'b0, "R1 mid-run reset");
        rst_n = 1'b1;
        idle(3, 1'b0);
      end
      cyc(lfsr[7:0], lfsr[9], ld, lfsr[15:13], lfsr[8], 1'b1, tg);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CYC_LIMIT * 20);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule